// File: doc/BRIEF.md
# Quadrature Encoder Count Capture

This block follows a two-phase quadrature signal from a rate sensor and keeps a running signed 16-bit position count. It decodes every edge of both phases, so each full input cycle moves the count by four. Both phases are synchronised to the system clock. The block compares the previous and present 2-bit phase state and turns each legal step into a one-cycle up or down pulse, and those pulses drive the counter. A step where both phases change at once is not counted. Such a step sets an error flag that stays set.

An external snapshot strobe copies the running count into a holding register. The counter itself is never cleared by the strobe. A host reads the holding register through a small synchronous read port. Between strobes the held value does not change, so a host can read it as often as it likes. One instance covers one channel. A system with three sensor axes uses three instances.

Top module: `qenc_capture`

## Requirements
- R1: After reset is asserted, the running count, the held value, `rd_data_o`, `rd_valid_o` and `err_o` are all zero.
- R2: Phase state is written as {A,B}. When A leads B, the legal forward sequence is 00, 10, 11, 01, 00. Each step in that sequence raises the count by one.
- R3: Each step in the reverse sequence (00, 01, 11, 10, 00) lowers the count by one.
- R4: A step where A and B change together (for example 00 to 11) leaves the count unchanged. It sets `err_o`, which stays at 1 until reset, including across later legal steps.
- R5: The count wraps modulo 2^16 in both directions. One down step from 0 gives 16'hFFFF, and one up step from 16'hFFFF gives 0. The value is two's complement.
- R6: A strobe on `snap_i` stores the present count in the holding register. The count keeps running and is not cleared. Without a strobe, the held value stays unchanged while the count moves.
- R7: If a decoded step reaches the counter in the same cycle that the strobe is sampled, the held value excludes that step. The next strobe includes it.
- R8: When `rd_i` is sampled high, `rd_data_o` shows the held value and `rd_valid_o` is 1 in the following cycle. `rd_valid_o` is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the highest quadrature rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ph_a_i | input | 1 | Phase A, asynchronous |
| ph_b_i | input | 1 | Phase B, asynchronous |
| snap_i | input | 1 | Snapshot strobe, synchronous |
| rd_i | input | 1 | Host read request |
| rd_data_o | output | 16 | Held count returned to the host |
| rd_valid_o | output | 1 | Read data valid |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
Several properties are checked on every cycle:
- The decoder never raises an up pulse and a down pulse together.
- Every up or down pulse moves the counter by exactly one.
- The error flag never falls once it is set.
- The held value changes only on a strobe, and it always equals the count from the cycle the strobe was sampled.
- Read valid follows a read request.

Some behaviour can only be shown by the bench scenarios:
- that the phase sequences map to the right count direction at the ports;
- that the count wraps around zero;
- that a dual-phase jump is rejected;
- that a step landing on the strobe cycle is deferred to the next snapshot.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_ERR  = 2'd3
  } step_e;

  // state is {a,b}; a leading b walks 00->10->11->01->00
  function automatic logic [1:0] fwd_state(input logic [1:0] s);
    return {~s[0], s[1]};
  endfunction

  function automatic step_e decode_step(input logic [1:0] prev, input logic [1:0] cur);
    if (prev == cur)                 return STEP_NONE;
    else if ((prev ^ cur) == 2'b11)  return STEP_ERR;
    else if (cur == fwd_state(prev)) return STEP_UP;
    else                             return STEP_DN;
  endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qenc_phase_dec.sv
module qenc_phase_dec
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       err_o
);
  logic [1:0] prev_q;
  step_e      step;

  assign step = decode_step(prev_q, ab_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      up_o   <= 1'b0;
      dn_o   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      prev_q <= ab_i;
      up_o   <= (step == STEP_UP);
      dn_o   <= (step == STEP_DN);
      if (step == STEP_ERR) err_o <= 1'b1;
    end
  end

  a_r2_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (up_i && !dn_i)     cnt_o <= cnt_o + CNT_W'(1);
    else if (dn_i && !up_i)     cnt_o <= cnt_o - CNT_W'(1);
  end

  a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !dn_i) |=> cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)));
  a_r3_dn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i) |=> cnt_o == CNT_W'($past(cnt_o) - CNT_W'(1)));
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i) |=> $stable(cnt_o));
endmodule

// File: rtl/qenc_capture.sv
module qenc_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ph_a_i,
  input  logic             ph_b_i,
  input  logic             snap_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             err_o
);
  logic [1:0]       ab_sync;
  logic             up_p, dn_p;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_q;

  qenc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ph_a_i, ph_b_i}),
    .q_o   (ab_sync)
  );

  qenc_phase_dec u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ab_i  (ab_sync),
    .up_o  (up_p),
    .dn_o  (dn_p),
    .err_o (err_o)
  );

  qenc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (up_p),
    .dn_i  (dn_p),
    .cnt_o (cnt)
  );

  // strobe samples the pre-update count, so a coincident step lands in the next snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (snap_i) hold_q <= cnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= hold_q;
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(hold_q));
  a_r7_snap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> hold_q == $past(cnt));
  a_r8_rd_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o);
endmodule

// File: tb/qenc_capture_bench.sv
module qenc_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_a = 1'b0, ph_b = 1'b0;
  logic        snap = 1'b0, rd = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid, err;

  int n_cmp = 0, n_bad = 0;
  logic [1:0]  st = 2'b00;
  logic [15:0] exp_cnt = '0;
  logic [15:0] exp_hold = '0;

  always #2.5 clk = ~clk;

  qenc_capture u_qenc_capture (
    .clk_i(clk), .rst_ni(rst_n), .ph_a_i(ph_a), .ph_b_i(ph_b),
    .snap_i(snap), .rd_i(rd), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .err_o(err)
  );

  function automatic logic [1:0] nxt(input logic [1:0] s, input bit up);
    return up ? {~s[0], s[1]} : {s[0], ~s[1]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input bit up, input int gap);
    @(negedge clk);
    st = nxt(st, up);
    {ph_a, ph_b} = st;
    exp_cnt = up ? exp_cnt + 16'd1 : exp_cnt - 16'd1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [15:0] expv);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check(req, {15'd0, rd_valid}, 16'd1);
    check(req, rd_data, expv);
  endtask

  task automatic settle_snap_read(input string req);
    repeat (6) @(negedge clk);
    do_snap();
    exp_hold = exp_cnt;
    do_read(req, exp_hold);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 rd_data", rd_data, 16'd0);
    check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R1 err", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read("R1 hold", 16'd0);

    // R5 wrap below zero and back
    step(1'b0, 4);
    settle_snap_read("R5 down wrap");
    step(1'b1, 4);
    settle_snap_read("R5 up wrap");

    // R2 forward cycles
    for (int i = 0; i < 8; i++) step(1'b1, 3 + ($urandom % 5));
    settle_snap_read("R2 forward");
    // R3 reverse cycles
    for (int i = 0; i < 12; i++) step(1'b0, 3 + ($urandom % 5));
    settle_snap_read("R3 reverse");

    // mixed random direction
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 40; i++) step(bit'($urandom % 2), 3 + ($urandom % 6));
      settle_snap_read("R2 R3 random");
    end

    // R8 no read: valid drops
    @(negedge clk);
    check("R8 valid idle", {15'd0, rd_valid}, 16'd0);

    // R6 hold unchanged while count moves, counter not cleared
    for (int i = 0; i < 5; i++) step(1'b1, 4);
    repeat (6) @(negedge clk);
    do_read("R6 hold stable", exp_hold);
    settle_snap_read("R6 keeps running");

    // R7 step reaching counter on the strobe cycle
    @(negedge clk);
    st = nxt(st, 1'b1);
    {ph_a, ph_b} = st;
    repeat (3) @(negedge clk);
    snap = 1'b1;
    @(negedge clk); snap = 1'b0;
    do_read("R7 excluded", exp_cnt);
    exp_cnt = exp_cnt + 16'd1;
    settle_snap_read("R7 next snap");

    // R4 illegal jump
    check("R4 err before", {15'd0, err}, 16'd0);
    @(negedge clk);
    st = ~st;
    {ph_a, ph_b} = st;
    settle_snap_read("R4 no count");
    check("R4 err set", {15'd0, err}, 16'd1);
    for (int i = 0; i < 3; i++) step(1'b1, 4);
    settle_snap_read("R4 legal after");
    check("R4 err sticky", {15'd0, err}, 16'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule